// File: doc/BRIEF.md
# SDRAM Command Sequencer with Software-Stepped Initialisation

This block is a compact SDRAM controller core controlled by software. A register port holds three registers: a configuration word with the array geometry, bus width, CAS latency and timing gaps; a mode selector; and a refresh interval. A memory port accepts single-word read and write requests that target the SDRAM window. The block drives the SDRAM command pins, bank address, address and write data, and it captures read data.

When a special mode is selected, each access to the window turns into exactly one SDRAM command: NOP, precharge-all, load-mode or auto-refresh. Software uses this to step through the power-up sequence one command at a time. For example, it writes the window eight times in auto-refresh mode to get eight refreshes. After the mode is set to normal and software makes a write access, accesses become single-beat activate, read or write, and precharge sequences. From then on the block inserts periodic auto-refresh commands. The block also reports the device capacity as a power of two.

Top module: `sdram_seq`

## Requirements
- R1: After reset the mode selector holds NOP (1) and the configuration is all zero, so the capacity output reads 22. The pins show deselect (cs_n=1), mem_ready is high and mem_rvalid is low. An access made straight after reset issues one NOP command (cs_n=0, ras_n=1, cas_n=1, we_n=1).
- R2: Register 1 selects the mode: 0 normal, 1 NOP, 2 precharge-all, 3 load-mode, 4 auto-refresh. In any mode other than 0, each accepted access issues exactly one command of that mode. No activate command is issued, sd_dq_oe stays low and mem_rvalid stays low.
- R3: Precharge-all drives address bit 10 high. Load-mode drives the bank address 0 and the address CAS latency shifted left by 4, with burst length 1 and sequential type (low four bits zero).
- R4: Register 0 holds the configuration: bits [1:0] column bits minus 8, [3:2] row bits minus 11, [4] bank bits minus 1, [5] 16-bit bus, [7:6] CAS latency, [11:8] tRCD, [15:12] tRP, [19:16] tRAS, [23:20] tWR, [27:24] tRC. A normal access splits the word address into row, bank and column from the most significant end. It then issues activate (bank, row), read or write (bank, column, address bit 10 low), and precharge of that bank (address bit 10 low). sd_dq_oe is high only in the write-command cycle, and it carries the request's data.
- R5: The read or write command follows activate by exactly tRCD cycles. The precharge follows a write by tWR cycles and a read by tRAS cycles. The next command comes at least tRP cycles after a precharge and at least tRC cycles after an auto-refresh. A timing field of 0 acts as 1.
- R6: Read data is presented on mem_rdata with a one-cycle mem_rvalid pulse. The pulse comes CAS latency plus 1 cycles after the read command appears on the pins, and the data is what the device drove CAS latency cycles after that command.
- R7: Register 2 sets the refresh interval in cycles. Automatic refresh runs only after mode 0 is selected and a write access has followed. It then issues an auto-refresh every interval cycles while the block is idle. An interval of 0 disables it.
- R8: A pending refresh takes priority over new accesses. While a refresh is outstanding or in progress, mem_ready stays low. An access waiting behind a refresh gets its activate no sooner than tRC cycles after the auto-refresh.
- R9: The capacity output gives log2 of the device size in bytes: row + column + bank bits + 1 for a 16-bit bus, or + 2 for a 32-bit bus.
- R10: Writing a non-zero mode stops automatic refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 configuration, 1 mode, 2 refresh interval |
| reg_wdata | input | 28 | Register write data |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 for write, 0 for read |
| mem_addr | input | 25 | Word address within the SDRAM window |
| mem_wdata | input | 32 | Write data |
| mem_ready | output | 1 | Request accepted in a cycle where mem_req and mem_ready are both high |
| mem_rdata | output | 32 | Read data |
| mem_rvalid | output | 1 | Read data valid pulse |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row, column or mode address |
| sd_dq_out | output | 32 | Write data to the pads |
| sd_dq_oe | output | 1 | Output enable for write data |
| sd_dq_in | input | 32 | Read data from the pads |
| cap_log2 | output | 5 | log2 of device capacity in bytes |

## Verification
The assertions assume that software writes the configuration and mode registers only while the block is idle with no access in flight. They also assume that the configured tRC is shorter than the refresh interval. The bench keeps to this: it waits for each sequence to drain before it writes a register, and it uses short fixed timings (tRCD 2, tRP 3, tRAS 4, tWR 2, tRC 5, CAS 2) against refresh intervals of 20 and 40. It also disables refresh while it inspects the command stream of a normal access, so that no auto-refresh interleaves with the expected activate, column and precharge triple.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  localparam int CFG_W  = 28;
  localparam int BA_W   = 2;
  localparam int COL_W  = 10;
  localparam int RDPIPE = 3;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PALL   = 3'd2,
    MODE_LMR    = 3'd3,
    MODE_AREF   = 3'd4
  } mode_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_AREF  = 4'b0001,
    CMD_LMR   = 4'b0000
  } cmd_e;

  typedef struct packed {
    logic [3:0] trc;
    logic [3:0] twr;
    logic [3:0] tras;
    logic [3:0] trp;
    logic [3:0] trcd;
    logic [1:0] cas;
    logic       bus16;
    logic       bank_m1;
    logic [1:0] row_m11;
    logic [1:0] col_m8;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT_WAIT, ST_COL_WAIT, ST_GAP
  } state_e;

  function automatic logic [3:0] at_least_one(input logic [3:0] t);
    return (t == 4'd0) ? 4'd1 : t;
  endfunction

endpackage

// File: rtl/sdram_addr_map.sv
module sdram_addr_map #(
  parameter int MAW = 25,
  parameter int SDA = 13
) (
  input  logic [MAW-1:0] addr_i,
  input  logic [1:0]     col_m8_i,
  input  logic [1:0]     row_m11_i,
  input  logic           bank_m1_i,
  output logic [SDA-1:0] row_o,
  output logic [1:0]     bank_o,
  output logic [9:0]     col_o
);
  logic [3:0] cbits, rbits, bbits;
  logic [SDA:0] rmask_w;

  always_comb begin
    cbits   = 4'd8 + {2'b00, col_m8_i};
    rbits   = 4'd11 + {2'b00, row_m11_i};
    bbits   = bank_m1_i ? 4'd2 : 4'd1;
    rmask_w = ((SDA+1)'(1) << rbits) - (SDA+1)'(1);
    col_o   = 10'(addr_i) & 10'((11'd1 << cbits) - 11'd1);
    bank_o  = 2'(addr_i >> cbits) & (bank_m1_i ? 2'b11 : 2'b01);
    row_o   = SDA'(addr_i >> (cbits + bbits)) & rmask_w[SDA-1:0];
  end
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable_i,
  input  logic [TW-1:0] period_i,
  output logic          tick_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable_i || period_i == '0) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == period_i - 1'b1) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
  import sdram_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_on_pins_i,
  input  logic [1:0]    cas_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [RDPIPE-1:0] pipe;
  logic hit;

  always_comb begin
    case (cas_i)
      2'd0, 2'd1: hit = pipe[0];
      2'd2:       hit = pipe[1];
      default:    hit = pipe[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      pipe     <= {pipe[RDPIPE-2:0], rd_on_pins_i};
      rvalid_o <= hit;
      if (hit) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int MAW = 25,
  parameter int DW  = 32,
  parameter int SDA = 13,
  parameter int TW  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [CFG_W-1:0] reg_wdata,
  input  logic             mem_req,
  input  logic             mem_we,
  input  logic [MAW-1:0]   mem_addr,
  input  logic [DW-1:0]    mem_wdata,
  output logic             mem_ready,
  output logic [DW-1:0]    mem_rdata,
  output logic             mem_rvalid,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [SDA-1:0]   sd_addr,
  output logic [DW-1:0]    sd_dq_out,
  output logic             sd_dq_oe,
  input  logic [DW-1:0]    sd_dq_in,
  output logic [4:0]       cap_log2
);
  cfg_t          cfg_q;
  logic [2:0]    mode_q;
  logic [TW-1:0] rint_q;
  logic          normal_on, ref_pend, rtick;
  state_e        state;
  logic [3:0]    gap;
  cmd_e          cmd_q;
  logic          lat_we;
  logic [9:0]    lat_col;
  logic [DW-1:0] lat_data;
  logic [SDA-1:0] map_row;
  logic [1:0]    map_bank;
  logic [9:0]    map_col;
  logic          accept;
  logic [3:0]    trcd_min;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign mem_ready = (state == ST_IDLE) && !ref_pend;
  assign accept    = mem_req && mem_ready;
  assign trcd_min  = at_least_one(cfg_q.trcd);

  sdram_addr_map #(.MAW(MAW), .SDA(SDA)) u_map (
    .addr_i(mem_addr), .col_m8_i(cfg_q.col_m8), .row_m11_i(cfg_q.row_m11),
    .bank_m1_i(cfg_q.bank_m1), .row_o(map_row), .bank_o(map_bank), .col_o(map_col)
  );

  sdram_refresh_timer #(.TW(TW)) u_rtmr (
    .clk(clk), .rst(rst), .enable_i(normal_on), .period_i(rint_q), .tick_o(rtick)
  );

  sdram_rd_capture #(.DW(DW)) u_rcap (
    .clk(clk), .rst(rst), .rd_on_pins_i(cmd_q == CMD_RD), .cas_i(cfg_q.cas),
    .dq_i(sd_dq_in), .rdata_o(mem_rdata), .rvalid_o(mem_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      mode_q    <= MODE_NOP;
      rint_q    <= '0;
      normal_on <= 1'b0;
      ref_pend  <= 1'b0;
      state     <= ST_IDLE;
      gap       <= '0;
      cmd_q     <= CMD_DESEL;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      lat_we    <= 1'b0;
      lat_col   <= '0;
      lat_data  <= '0;
      cap_log2  <= '0;
    end else begin
      cmd_q    <= CMD_DESEL;
      sd_dq_oe <= 1'b0;
      cap_log2 <= 5'd20 + {3'b0, cfg_q.row_m11} + {3'b0, cfg_q.col_m8}
                + {4'b0, cfg_q.bank_m1} + (cfg_q.bus16 ? 5'd1 : 5'd2);
      if (rtick) ref_pend <= 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_q    <= CMD_AREF;
            ref_pend <= rtick;
            gap      <= at_least_one(cfg_q.trc) - 4'd1;
            state    <= ST_GAP;
          end else if (accept) begin
            state <= ST_GAP;
            gap   <= '0;
            if (mode_q == MODE_NORMAL) begin
              cmd_q    <= CMD_ACT;
              sd_ba    <= map_bank;
              sd_addr  <= map_row;
              lat_we   <= mem_we;
              lat_col  <= map_col;
              lat_data <= mem_wdata;
              gap      <= trcd_min - 4'd1;
              state    <= ST_ACT_WAIT;
              if (mem_we) normal_on <= 1'b1;
            end else begin
              unique case (mode_q)
                MODE_PALL: begin
                  cmd_q       <= CMD_PRE;
                  sd_addr     <= '0;
                  sd_addr[10] <= 1'b1;
                  gap         <= at_least_one(cfg_q.trp) - 4'd1;
                end
                MODE_LMR: begin
                  cmd_q   <= CMD_LMR;
                  sd_ba   <= '0;
                  sd_addr <= {{(SDA-6){1'b0}}, cfg_q.cas, 4'b0000};
                  gap     <= 4'd1;
                end
                MODE_AREF: begin
                  cmd_q <= CMD_AREF;
                  gap   <= at_least_one(cfg_q.trc) - 4'd1;
                end
                default: cmd_q <= CMD_NOP;
              endcase
            end
          end
        end
        ST_ACT_WAIT: begin
          if (gap != 4'd0) gap <= gap - 4'd1;
          else begin
            cmd_q     <= lat_we ? CMD_WR : CMD_RD;
            sd_addr   <= {{(SDA-11){1'b0}}, 1'b0, lat_col};
            sd_dq_oe  <= lat_we;
            sd_dq_out <= lat_data;
            gap       <= (lat_we ? at_least_one(cfg_q.twr) : at_least_one(cfg_q.tras)) - 4'd1;
            state     <= ST_COL_WAIT;
          end
        end
        ST_COL_WAIT: begin
          if (gap != 4'd0) gap <= gap - 4'd1;
          else begin
            cmd_q   <= CMD_PRE;
            sd_addr <= '0;
            gap     <= at_least_one(cfg_q.trp) - 4'd1;
            state   <= ST_GAP;
          end
        end
        default: begin
          if (gap != 4'd0) gap <= gap - 4'd1;
          else state <= ST_IDLE;
        end
      endcase

      if (reg_wr) begin
        case (reg_sel)
          2'd0: cfg_q <= cfg_t'(reg_wdata);
          2'd1: begin
            mode_q <= reg_wdata[2:0];
            if (reg_wdata[2:0] != 3'd0) normal_on <= 1'b0;
          end
          2'd2: rint_q <= reg_wdata[TW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int SDA = 13
) (
  input logic           clk,
  input logic           rst,
  input logic           sd_cs_n,
  input logic           sd_ras_n,
  input logic           sd_cas_n,
  input logic           sd_we_n,
  input logic [1:0]     sd_ba,
  input logic [SDA-1:0] sd_addr,
  input logic           sd_dq_oe,
  input logic           mem_req,
  input logic           mem_ready,
  input logic           mem_rvalid,
  input logic [2:0]     mode_q,
  input logic [3:0]     trcd_min
);
  logic [3:0] pins;
  logic [3:0] since_act;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) since_act <= 4'hF;
    else if (pins == 4'b0011) since_act <= 4'd1;
    else if (since_act != 4'hF) since_act <= since_act + 4'd1;
  end

  // R4
  oe_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> (pins == 4'b0100));

  // R2
  no_activate_in_special_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) != 3'd0) |-> (pins != 4'b0011));

  // R3
  load_mode_bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0000) |-> (sd_ba == 2'd0 && sd_addr[3:0] == 4'd0));

  // R5
  column_after_activate_chk: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0101 || pins == 4'b0100) |-> (since_act == trcd_min));

  // R6
  rvalid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |=> !mem_rvalid);

  // R8
  accept_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> !mem_ready);

  // R8
  refresh_holds_ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pins == 4'b0001) |-> !mem_ready);
endmodule

bind sdram_seq sdram_seq_chk #(.SDA(SDA)) u_chk (
  .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
  .sd_dq_oe(sd_dq_oe), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_rvalid(mem_rvalid), .mode_q(mode_q), .trcd_min(trcd_min)
);

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_AREF = 4'b0001,
                         C_LMR = 4'b0000;
  localparam int CAS = 2, TRCD = 2, TRP = 3, TRAS = 4, TWR = 2, TRC = 5;

  logic clk = 0, rst = 1;
  logic reg_wr = 0; logic [1:0] reg_sel = 0; logic [27:0] reg_wdata = 0;
  logic mem_req = 0, mem_we = 0; logic [24:0] mem_addr = 0; logic [31:0] mem_wdata = 0;
  logic mem_ready, mem_rvalid; logic [31:0] mem_rdata;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n; logic [1:0] sd_ba; logic [12:0] sd_addr;
  logic [31:0] sd_dq_out; logic sd_dq_oe; logic [31:0] sd_dq_in = 0; logic [4:0] cap_log2;

  sdram_seq dut (.*);

  always #10 clk = ~clk;

  typedef struct { logic [3:0] c; logic [1:0] ba; logic [12:0] a; logic [31:0] d; int t; } ev_t;
  typedef struct { logic [31:0] d; int t; } rv_t;
  ev_t log_q[$];
  rv_t rv_q[$];
  int cyc = 0, oe_seen = 0, rd_due = -1, n_chk = 0, n_fail = 0;
  bit aref_flag = 0, done = 0;
  logic [31:0] rd_val = 0;
  logic [12:0] open_row [4];
  logic [31:0] mem [int];

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural device and pin monitor
  always @(negedge clk) begin
    logic [3:0] c; int key;
    sd_dq_in = (cyc == rd_due) ? rd_val : 32'h0;
    if (!rst) begin
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (sd_dq_oe) oe_seen++;
      if (!sd_cs_n) begin
        log_q.push_back('{c: c, ba: sd_ba, a: sd_addr, d: sd_dq_out, t: cyc});
        key = int'({sd_ba, open_row[sd_ba], sd_addr[9:0]});
        if (c == C_AREF) aref_flag = 1;
        if (c == C_ACT) open_row[sd_ba] = sd_addr;
        if (c == C_WR) mem[key] = sd_dq_out;
        if (c == C_RD) begin rd_val = mem.exists(key) ? mem[key] : 32'h0; rd_due = cyc + CAS; end
      end
      if (mem_rvalid) rv_q.push_back('{d: mem_rdata, t: cyc});
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input int act, input int lim);
    n_chk++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
    end
  endtask

  function automatic logic [27:0] mk_cfg(int cm, int rm, int bm, int b16);
    return 28'(cm | rm << 2 | bm << 4 | b16 << 5 | CAS << 6 | TRCD << 8 |
               TRP << 12 | TRAS << 16 | TWR << 20 | TRC << 24);
  endfunction

  task automatic wr_reg(input logic [1:0] s, input logic [27:0] v);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic access(input bit we, input logic [24:0] a, input logic [31:0] d);
    @(negedge clk); mem_req = 1; mem_we = we; mem_addr = a; mem_wdata = d;
    while (!mem_ready) @(negedge clk);
    @(negedge clk); mem_req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int count_cmd(input logic [3:0] c);
    int n = 0;
    foreach (log_q[i]) if (log_q[i].c == c) n++;
    return n;
  endfunction

  function automatic logic [24:0] waddr(int row, int bank, int col);
    return 25'(row << 11 | bank << 9 | col);
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready", mem_ready, 1);
    chk("R1", "cs_n", sd_cs_n, 1);
    chk("R1", "rvalid", mem_rvalid, 0);
    chk("R1", "capacity", cap_log2, 22);
    log_q.delete(); access(1, 0, 32'h1); idle(6);
    chk("R1", "cmd count after reset", log_q.size(), 1);
    if (log_q.size() > 0) chk("R1", "reset mode is NOP", log_q[0].c, C_NOP);

    // R9 capacity
    wr_reg(0, mk_cfg(1, 1, 1, 1)); idle(3);
    chk("R9", "capacity 16-bit", cap_log2, 24);
    wr_reg(0, mk_cfg(1, 1, 1, 0)); idle(3);
    chk("R9", "capacity 32-bit", cap_log2, 25);

    // R7 no refresh before normal operation starts
    wr_reg(2, 20); log_q.delete(); idle(60);
    chk("R7", "aref before normal", count_cmd(C_AREF), 0);

    // R2 R3 precharge-all
    wr_reg(1, 2); log_q.delete(); oe_seen = 0;
    access(1, waddr(3, 1, 5), 32'hAAAA); idle(10);
    chk("R2", "pall cmd count", log_q.size(), 1);
    if (log_q.size() > 0) begin
      chk("R2", "pall cmd", log_q[0].c, C_PRE);
      chk("R3", "pall A10", log_q[0].a[10], 1);
    end

    // R2 R5 eight auto-refreshes
    wr_reg(1, 4); log_q.delete();
    for (int i = 0; i < 8; i++) access(1, 25'(i), 32'h0);
    idle(10);
    chk("R2", "aref count", log_q.size(), 8);
    chk("R2", "aref only", count_cmd(C_AREF), 8);
    for (int i = 1; i < log_q.size(); i++)
      chk_ge("R5", "aref spacing", log_q[i].t - log_q[i-1].t, TRC);

    // R3 load mode
    wr_reg(1, 3); log_q.delete();
    access(1, waddr(7, 3, 9), 32'h0); idle(8);
    chk("R3", "lmr count", log_q.size(), 1);
    if (log_q.size() > 0) begin
      chk("R3", "lmr cmd", log_q[0].c, C_LMR);
      chk("R3", "lmr addr", log_q[0].a, CAS << 4);
      chk("R3", "lmr bank", log_q[0].ba, 0);
    end
    chk("R2", "no data drive in special modes", oe_seen, 0);
    chk("R2", "no read data in special modes", rv_q.size(), 0);

    // R4 R5 normal write
    wr_reg(2, 0); wr_reg(1, 0); log_q.delete(); oe_seen = 0;
    access(1, waddr(12'h5A3, 2, 9'h1C7), 32'hCAFE_0001); idle(15);
    chk("R4", "write seq length", log_q.size(), 3);
    if (log_q.size() == 3) begin
      chk("R4", "act", log_q[0].c, C_ACT);
      chk("R4", "act row", log_q[0].a, 12'h5A3);
      chk("R4", "act bank", log_q[0].ba, 2);
      chk("R4", "wr", log_q[1].c, C_WR);
      chk("R4", "wr col", log_q[1].a, 9'h1C7);
      chk("R4", "wr data", log_q[1].d, 32'hCAFE_0001);
      chk("R4", "pre", log_q[2].c, C_PRE);
      chk("R4", "pre bank", log_q[2].ba, 2);
      chk("R4", "pre A10", log_q[2].a[10], 0);
      chk("R5", "trcd", log_q[1].t - log_q[0].t, TRCD);
      chk("R5", "twr", log_q[2].t - log_q[1].t, TWR);
    end
    chk("R4", "oe cycles", oe_seen, 1);

    // R4 R6 second location, reads
    access(1, waddr(12'h0F0, 1, 9'h003), 32'h1234_5678); idle(12);
    log_q.delete(); rv_q.delete();
    access(0, waddr(12'h5A3, 2, 9'h1C7), 32'h0); idle(15);
    chk("R4", "read seq length", log_q.size(), 3);
    chk("R6", "rvalid count", rv_q.size(), 1);
    if (log_q.size() == 3 && rv_q.size() == 1) begin
      chk("R4", "rd", log_q[1].c, C_RD);
      chk("R5", "rd trcd", log_q[1].t - log_q[0].t, TRCD);
      chk("R5", "tras", log_q[2].t - log_q[1].t, TRAS);
      chk("R6", "read data A", rv_q[0].d, 32'hCAFE_0001);
      chk("R6", "read latency", rv_q[0].t - log_q[1].t, CAS + 1);
    end
    log_q.delete(); rv_q.delete();
    access(0, waddr(12'h0F0, 1, 9'h003), 32'h0); idle(15);
    chk("R6", "rvalid count B", rv_q.size(), 1);
    if (rv_q.size() == 1) chk("R6", "read data B", rv_q[0].d, 32'h1234_5678);
    if (log_q.size() > 0) chk("R4", "read B row", log_q[0].a, 12'h0F0);
    log_q.delete(); rv_q.delete();
    access(1, waddr(12'h0F0, 1, 9'h003), 32'h0BAD_F00D); idle(12);
    log_q.delete();
    access(0, waddr(12'h0F0, 1, 9'h003), 32'h0); idle(15);
    if (log_q.size() > 0) chk("R5", "act after pre spacing ok", log_q[0].c, C_ACT);
    chk("R6", "overwritten data", rv_q.size() == 1 ? rv_q[0].d : 32'hFFFF_FFFF, 32'h0BAD_F00D);

    // R7 zero interval disables
    log_q.delete(); idle(80);
    chk("R7", "aref with interval 0", count_cmd(C_AREF), 0);

    // R7 periodic refresh
    wr_reg(2, 40); log_q.delete(); idle(170);
    chk_ge("R7", "aref count", count_cmd(C_AREF), 3);
    for (int i = 1; i < log_q.size(); i++)
      chk("R7", "aref interval", log_q[i].t - log_q[i-1].t, 40);

    // R8 refresh priority over access
    aref_flag = 0;
    for (int i = 0; i < 200 && !aref_flag; i++) @(negedge clk);
    chk("R8", "ready low during refresh", mem_ready, 0);
    log_q.delete(); rv_q.delete(); aref_flag = 0;
    for (int i = 0; i < 200 && !aref_flag; i++) @(negedge clk);
    mem_req = 1; mem_we = 0; mem_addr = waddr(12'h5A3, 2, 9'h1C7);
    while (!mem_ready) @(negedge clk);
    @(negedge clk); mem_req = 0; idle(15);
    begin
      int ta = -1, tc = -1;
      foreach (log_q[i]) begin
        if (log_q[i].c == C_AREF) ta = log_q[i].t;
        if (log_q[i].c == C_ACT && ta >= 0 && tc < 0) tc = log_q[i].t;
      end
      chk_ge("R8", "act after refresh", tc - ta, TRC);
    end
    chk("R8", "stalled read data", rv_q.size() == 1 ? rv_q[0].d : 32'hFFFF_FFFF, 32'hCAFE_0001);

    // R10 non-zero mode stops refresh
    wr_reg(1, 1); idle(8); log_q.delete(); idle(100);
    chk("R10", "aref after mode change", count_cmd(C_AREF), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule